// File: doc/BRIEF.md
# Standby Power-State Clock Controller

This block sits beside a CPU core and decides which clock domains run. It tracks four power states: running, basic HALT, HALT2 and SLEEP. Each standby depth switches off a larger set of clock enables. The core requests HALT or SLEEP with single-cycle strobes. A configuration bit picks which HALT depth the halt strobe selects. An external bus master can also park the CPU in basic HALT by raising a bus request, provided release is enabled.

Enabled interrupts wake the core from the instruction-entered states. Port interrupt lines act as level triggers while in standby, whatever trigger is configured for them. When the core leaves SLEEP, the fast oscillator starts first. The CPU clock then stays gated for a programmable number of low-speed clock ticks so the oscillator can settle. A low-speed oscillator enable bit and a DRAM refresh enable output complete the block.

Top module: `standby_ctrl`

## Requirements
- R1: With the halt-depth bit at 0, a halt strobe in running moves to basic HALT (mode 01). In that state only the CPU and DMA enables are low.
- R2: With the halt-depth bit at 1, a halt strobe in running moves to HALT2 (mode 10). In that state the CPU, bus-unit and DMA enables are low, and the fast oscillator and prescaler enables stay high.
- R3: A sleep strobe in running moves to SLEEP (mode 11) with all six clock enables low. A sleep strobe wins over a halt strobe in the same cycle.
- R4: After reset the mode is 00, all clock enables are high, the halt-depth bit is 0 and the low-speed oscillator enable is 1.
- R5: In running, a bus request while bus release is enabled moves to basic HALT (mode 01). With release disabled, a bus request has no effect.
- R6: Any interrupt whose mask bit is set returns basic HALT (when entered by the halt strobe), HALT2 or SLEEP towards running. Masked interrupts are ignored. Basic HALT entered by bus request is not left on an interrupt.
- R7: Basic HALT entered by bus request returns to running on the clock edge that samples the bus request low.
- R8: An interrupt in SLEEP turns on the fast oscillator only. Mode stays 11 and the CPU clock stays off until the stabilisation count of low-speed ticks has elapsed; running resumes on the edge of the last tick. A count of 0 resumes running at once.
- R9: Port trigger outputs are registered. In running, a port set to edge mode fires for one cycle on a rising level, and a port set to level mode follows the level. In any standby state every enabled port is level-triggered, and an active level wakes the core.
- R10: The low-speed oscillator enable follows its configuration bit and stays on through SLEEP.
- R11: The DRAM refresh enable is low whenever mode bit 1 is set (HALT2, SLEEP, oscillator settling) and high otherwise.
- R12: The CPU clock enable is high only in mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Halt instruction strobe |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| cfg_we_i | input | 1 | Write strobe for configuration bits |
| cfg_halt2_sel_i | input | 1 | New halt-depth bit (1 selects HALT2) |
| cfg_losc_on_i | input | 1 | New low-speed oscillator enable bit |
| busreq_i | input | 1 | External bus master request |
| busrel_en_i | input | 1 | Allows bus request to halt the CPU |
| irq_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Interrupt mask, 1 enables |
| port_i | input | N_PORT | Port interrupt pin levels |
| port_en_i | input | N_PORT | Port interrupt enables |
| port_edge_i | input | N_PORT | Trigger select per port, 1 edge, 0 level |
| ls_tick_i | input | 1 | One-cycle pulse per low-speed clock period |
| stab_cnt_i | input | STAB_W | Oscillator settling time in low-speed ticks |
| mode_o | output | 2 | 00 running, 01 basic HALT, 10 HALT2, 11 SLEEP |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| bus_clk_en_o | output | 1 | Bus control unit and bus clock enable |
| dma_clk_en_o | output | 1 | DMA clock enable |
| fosc_en_o | output | 1 | Fast oscillator enable |
| psc_clk_en_o | output | 1 | Prescaler and prescaler-fed peripheral enable |
| losc_en_o | output | 1 | Low-speed oscillator enable |
| dram_ref_en_o | output | 1 | DRAM refresh enable |
| port_trig_o | output | N_PORT | Registered port interrupt triggers |

## Verification
A wrong state register shows one cycle after the stimulus edge. It appears as a mode code or clock-enable set that matches no legal combination, or as a wrong state in the wake sequence. A bus-request halt that is wrongly marked as instruction-entered shows up as an early return to 00 on an interrupt. A wrong settling counter moves the rise of the CPU enable by whole low-speed ticks, which the bench counts. A missing forced-level trigger in standby leaves the block in HALT while a port pin is held high.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT_I,
    ST_HALT_B,
    ST_HALT2,
    ST_SLEEP,
    ST_WARM
  } pwr_state_e;

  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_HALT  = 2'b01;
  localparam logic [1:0] MODE_HALT2 = 2'b10;
  localparam logic [1:0] MODE_SLEEP = 2'b11;
endpackage

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  // last tick of the window
  assign expire_o = tick_i && (cnt_q <= CW'(1));
endmodule

// File: rtl/port_wake.sv
module port_wake #(
  parameter int NP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] port_i,
  input  logic [NP-1:0] port_en_i,
  input  logic [NP-1:0] edge_sel_i,
  input  logic          standby_i,
  output logic          wake_o,
  output logic [NP-1:0] trig_o
);
  logic [NP-1:0] prev_q, trig_c;

  for (genvar g = 0; g < NP; g++) begin : g_port
    // standby forces level sensing
    assign trig_c[g] = port_en_i[g] && port_i[g] &&
                       (standby_i || !edge_sel_i[g] || !prev_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      trig_o <= '0;
    end else begin
      prev_q <= port_i;
      trig_o <= trig_c;
    end
  end

  assign wake_o = standby_i && (|trig_c);
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          halt_req_i,
  input  logic          sleep_req_i,
  input  logic          halt2_sel_i,
  input  logic          busreq_i,
  input  logic          busrel_en_i,
  input  logic          wake_i,
  input  logic          ls_tick_i,
  input  logic [CW-1:0] stab_cnt_i,
  output pwr_state_e    state_o
);
  pwr_state_e state_q, state_d;
  logic       load, expire;

  assign load = (state_q == ST_SLEEP) && wake_i && (stab_cnt_i != '0);

  stab_timer #(.CW(CW)) i_stab_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(stab_cnt_i),
    .tick_i    (ls_tick_i),
    .expire_o  (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req_i)                 state_d = ST_SLEEP;
        else if (halt_req_i)             state_d = halt2_sel_i ? ST_HALT2 : ST_HALT_I;
        else if (busreq_i && busrel_en_i) state_d = ST_HALT_B;
      end
      ST_HALT_I, ST_HALT2: if (wake_i) state_d = ST_RUN;
      ST_HALT_B:           if (!busreq_i) state_d = ST_RUN;
      ST_SLEEP:            if (wake_i) state_d = (stab_cnt_i == '0) ? ST_RUN : ST_WARM;
      ST_WARM:             if (expire) state_d = ST_RUN;
      default:             state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int N_IRQ  = 4,
  parameter int N_PORT = 2,
  parameter int STAB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              sleep_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_halt2_sel_i,
  input  logic              cfg_losc_on_i,
  input  logic              busreq_i,
  input  logic              busrel_en_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_PORT-1:0] port_i,
  input  logic [N_PORT-1:0] port_en_i,
  input  logic [N_PORT-1:0] port_edge_i,
  input  logic              ls_tick_i,
  input  logic [STAB_W-1:0] stab_cnt_i,
  output logic [1:0]        mode_o,
  output logic              cpu_clk_en_o,
  output logic              bus_clk_en_o,
  output logic              dma_clk_en_o,
  output logic              fosc_en_o,
  output logic              psc_clk_en_o,
  output logic              losc_en_o,
  output logic              dram_ref_en_o,
  output logic [N_PORT-1:0] port_trig_o
);
  logic       halt2_sel_q, losc_on_q;
  logic       port_wake_s, wake;
  pwr_state_e state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt2_sel_q <= 1'b0;
      losc_on_q   <= 1'b1;
    end else if (cfg_we_i) begin
      halt2_sel_q <= cfg_halt2_sel_i;
      losc_on_q   <= cfg_losc_on_i;
    end
  end

  port_wake #(.NP(N_PORT)) i_port_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_i    (port_i),
    .port_en_i (port_en_i),
    .edge_sel_i(port_edge_i),
    .standby_i (state != ST_RUN),
    .wake_o    (port_wake_s),
    .trig_o    (port_trig_o)
  );

  assign wake = (|(irq_i & irq_en_i)) || port_wake_s;

  standby_fsm #(.CW(STAB_W)) i_standby_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_req_i (halt_req_i),
    .sleep_req_i(sleep_req_i),
    .halt2_sel_i(halt2_sel_q),
    .busreq_i   (busreq_i),
    .busrel_en_i(busrel_en_i),
    .wake_i     (wake),
    .ls_tick_i  (ls_tick_i),
    .stab_cnt_i (stab_cnt_i),
    .state_o    (state)
  );

  always_comb begin
    {cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, fosc_en_o, psc_clk_en_o, dram_ref_en_o} = 6'b111111;
    mode_o = MODE_RUN;
    unique case (state)
      ST_HALT_I, ST_HALT_B: begin
        mode_o = MODE_HALT;
        {cpu_clk_en_o, dma_clk_en_o} = 2'b00;
      end
      ST_HALT2: begin
        mode_o = MODE_HALT2;
        {cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, dram_ref_en_o} = 4'b0000;
      end
      ST_SLEEP: begin
        mode_o = MODE_SLEEP;
        {cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, fosc_en_o, psc_clk_en_o, dram_ref_en_o} = 6'b000000;
      end
      ST_WARM: begin
        mode_o = MODE_SLEEP;
        {cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, psc_clk_en_o, dram_ref_en_o} = 5'b00000;
      end
      default: ;
    endcase
  end

  assign losc_en_o = losc_on_q;
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_req_i,
  input logic       sleep_req_i,
  input logic       busreq_i,
  input logic       busrel_en_i,
  input logic [1:0] mode_o,
  input logic       cpu_clk_en_o,
  input logic       bus_clk_en_o,
  input logic       dma_clk_en_o,
  input logic       fosc_en_o,
  input logic       psc_clk_en_o,
  input logic       dram_ref_en_o
);
  assert_halt_gates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> !cpu_clk_en_o && !dma_clk_en_o && bus_clk_en_o && fosc_en_o && psc_clk_en_o);

  assert_halt2_gates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> !cpu_clk_en_o && !bus_clk_en_o && !dma_clk_en_o && fosc_en_o && psc_clk_en_o);

  assert_sleep_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && sleep_req_i) |=> mode_o == 2'b11);

  assert_bus_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && !sleep_req_i && !halt_req_i && busreq_i && busrel_en_i) |=> mode_o == 2'b01);

  assert_osc_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> fosc_en_o && psc_clk_en_o);

  assert_no_refresh_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> !dram_ref_en_o);

  assert_cpu_run_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> mode_o == 2'b00);
endmodule

bind standby_ctrl standby_ctrl_chk i_standby_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .halt_req_i   (halt_req_i),
  .sleep_req_i  (sleep_req_i),
  .busreq_i     (busreq_i),
  .busrel_en_i  (busrel_en_i),
  .mode_o       (mode_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .bus_clk_en_o (bus_clk_en_o),
  .dma_clk_en_o (dma_clk_en_o),
  .fosc_en_o    (fosc_en_o),
  .psc_clk_en_o (psc_clk_en_o),
  .dram_ref_en_o(dram_ref_en_o)
);

// File: tb/test_standby_ctrl.sv
`timescale 1ns/1ps
module test_standby_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       halt_req_i = 0, sleep_req_i = 0, cfg_we_i = 0, cfg_halt2_sel_i = 0, cfg_losc_on_i = 1;
  logic       busreq_i = 0, busrel_en_i = 0, ls_tick_i = 0;
  logic [3:0] irq_i = '0, irq_en_i = 4'b0010;
  logic [1:0] port_i = '0, port_en_i = 2'b11, port_edge_i = 2'b01;
  logic [7:0] stab_cnt_i = 8'd3;
  logic [1:0] mode_o, port_trig_o;
  logic       cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, fosc_en_o, psc_clk_en_o, losc_en_o, dram_ref_en_o;

  always #2.5 clk_i = ~clk_i;

  standby_ctrl i_standby_ctrl (.*);

  typedef struct {
    string      req;
    logic [10:0] val;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // enable order: cpu, bus, dma, fosc, psc, dram
  localparam logic [5:0] EN_RUN = 6'b111111, EN_HALT = 6'b010111, EN_HALT2 = 6'b000110,
                         EN_SLP = 6'b000000, EN_WARM = 6'b000100;

  function automatic logic [10:0] ev(logic [1:0] m, logic [5:0] en, logic lo, logic [1:0] tr);
    return {m, en, lo, tr};
  endfunction

  task automatic step(string req, logic [10:0] e);
    exp_t it;
    it.req = req;
    it.val = e;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      logic [10:0] act;
      it  = q.pop_front();
      act = {mode_o, cpu_clk_en_o, bus_clk_en_o, dma_clk_en_o, fosc_en_o, psc_clk_en_o,
             dram_ref_en_o, losc_en_o, port_trig_o};
      n_chk++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", it.req, act, it.val);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R4", ev(2'b00, EN_RUN, 1, 2'b00));
    // R1 basic HALT by strobe
    halt_req_i = 1; step("R1", ev(2'b01, EN_HALT, 1, 2'b00)); halt_req_i = 0;
    irq_i = 4'b0001; step("R6", ev(2'b01, EN_HALT, 1, 2'b00));
    irq_i = 4'b0010; step("R6", ev(2'b00, EN_RUN, 1, 2'b00)); irq_i = 0;
    // R2 HALT2
    cfg_we_i = 1; cfg_halt2_sel_i = 1; step("R2", ev(2'b00, EN_RUN, 1, 2'b00)); cfg_we_i = 0;
    halt_req_i = 1; step("R2", ev(2'b10, EN_HALT2, 1, 2'b00)); halt_req_i = 0;
    step("R11", ev(2'b10, EN_HALT2, 1, 2'b00));
    irq_i = 4'b0010; step("R6", ev(2'b00, EN_RUN, 1, 2'b00)); irq_i = 0;
    // R3 sleep wins over halt
    sleep_req_i = 1; halt_req_i = 1; step("R3", ev(2'b11, EN_SLP, 1, 2'b00));
    sleep_req_i = 0; halt_req_i = 0; step("R10", ev(2'b11, EN_SLP, 1, 2'b00));
    // R8 settling over 3 ticks
    irq_i = 4'b0010; step("R8", ev(2'b11, EN_WARM, 1, 2'b00)); irq_i = 0;
    ls_tick_i = 1; step("R8", ev(2'b11, EN_WARM, 1, 2'b00)); ls_tick_i = 0;
    step("R8", ev(2'b11, EN_WARM, 1, 2'b00));
    ls_tick_i = 1; step("R8", ev(2'b11, EN_WARM, 1, 2'b00)); ls_tick_i = 0;
    step("R11", ev(2'b11, EN_WARM, 1, 2'b00));
    ls_tick_i = 1; step("R8", ev(2'b00, EN_RUN, 1, 2'b00)); ls_tick_i = 0;
    // R8 zero count
    stab_cnt_i = 0; sleep_req_i = 1; step("R3", ev(2'b11, EN_SLP, 1, 2'b00)); sleep_req_i = 0;
    irq_i = 4'b0010; step("R8", ev(2'b00, EN_RUN, 1, 2'b00)); irq_i = 0; stab_cnt_i = 3;
    // R5 / R7 bus request halt
    busreq_i = 1; step("R5", ev(2'b00, EN_RUN, 1, 2'b00));
    busrel_en_i = 1; step("R5", ev(2'b01, EN_HALT, 1, 2'b00));
    irq_i = 4'b0010; step("R6", ev(2'b01, EN_HALT, 1, 2'b00)); irq_i = 0;
    step("R7", ev(2'b01, EN_HALT, 1, 2'b00));
    busreq_i = 0; step("R7", ev(2'b00, EN_RUN, 1, 2'b00)); busrel_en_i = 0;
    // R9 port triggers: port0 edge, port1 level
    port_i = 2'b01; step("R9", ev(2'b00, EN_RUN, 1, 2'b01));
    step("R9", ev(2'b00, EN_RUN, 1, 2'b00));
    port_i = 2'b11; step("R9", ev(2'b00, EN_RUN, 1, 2'b10));
    step("R9", ev(2'b00, EN_RUN, 1, 2'b10));
    port_i = 2'b01; step("R9", ev(2'b00, EN_RUN, 1, 2'b00));
    halt_req_i = 1; step("R9", ev(2'b10, EN_HALT2, 1, 2'b00)); halt_req_i = 0;
    step("R9", ev(2'b00, EN_RUN, 1, 2'b01));
    step("R9", ev(2'b00, EN_RUN, 1, 2'b00));
    port_i = 2'b00; step("R9", ev(2'b00, EN_RUN, 1, 2'b00));
    // R10 low-speed osc off, halt depth back to basic
    cfg_we_i = 1; cfg_losc_on_i = 0; cfg_halt2_sel_i = 0; step("R10", ev(2'b00, EN_RUN, 0, 2'b00));
    cfg_we_i = 0;
    halt_req_i = 1; step("R1", ev(2'b01, EN_HALT, 0, 2'b00)); halt_req_i = 0;
    irq_i = 4'b0010; step("R12", ev(2'b00, EN_RUN, 0, 2'b00)); irq_i = 0;
    @(negedge clk_i);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule